// File: doc/BRIEF.md
# Modem Control and Ring Status Logic

This block is the modem-handshake slice of a UART register file. It holds the modem control register, whose bits drive two active-low outputs: a request-to-send line and a general-purpose user output. A loop-test input overrides both control bits, so while loop test is on both pins stay at their inactive high level.

The block also produces the modem status register for the ring-indicator line. The active-low ring input passes through a two-flop synchroniser. The status register reports the synchronised level inverted, so the bit reads 1 while a ring is present. It also keeps a sticky flag that sets when the ring input goes from low to high, which is the end of a ring burst. A strobed read of the status register clears the flag. When the modem-status interrupt enable is on, a set flag raises the interrupt request.

The register port has a 3-bit address. Read data is combinational from the address alone. The read strobe only marks the access that clears the flag.

Top module: `mdm_ctl_status`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control register is cleared to 0 and the ring flag is cleared. After that edge, `rts_n` and `out2_n` are 1 and `irq` is 0.
- R2: A write to address 4 stores `wdata[4:0]` in the control register. Reading address 4 returns those five bits in `rdata[4:0]`, and `rdata[7:5]` reads 0.
- R3: With `loop_en` low, `rts_n` equals the inverse of control bit 1.
- R4: With `loop_en` low, `out2_n` equals the inverse of control bit 3.
- R5: With `loop_en` high, `rts_n` and `out2_n` are both 1 whatever the control bits hold. The stored control value is not changed and reads back intact.
- R6: At address 6, status bit 6 reads the inverse of `ri_n`, delayed by two clock edges through the synchroniser.
- R7: Status bit 2 sets on the third clock edge after `ri_n` goes from 0 to 1. A 1-to-0 change on `ri_n` never sets it.
- R8: A read of address 6 with `rd_en` high clears status bit 2 at that clock edge. If a new low-to-high ring event is detected in the same cycle, the bit stays set. Without a strobed read, the bit stays set.
- R9: `irq` is 1 exactly when status bit 2 is set and `ms_irq_en` is 1.
- R10: Status bits 7, 5:3 and 1:0 read 0. A write to address 6 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only) |
| addr | input | 3 | Register address (4 = control, 6 = status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| loop_en | input | 1 | Loop-test mode, forces user outputs inactive |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| ri_n | input | 1 | Asynchronous active-low ring indicator |
| rts_n | output | 1 | Active-low request-to-send |
| out2_n | output | 1 | Active-low user output |
| irq | output | 1 | Modem-status interrupt request |

## Verification
All 32 control values are written under both loop settings. This tells a wrong bit position or a missing inversion apart from a loop override that fails to mask, or one that corrupts the stored value. The ring input is driven through falling and rising transitions, and status is looked at after each clock edge with the address alone. This shows the synchroniser latency and catches a detector that fires on the wrong edge. Reads with and without the strobe, and a strobed read that lands on the same cycle as a fresh rising event, separate a correct clear from a lost event or a flag that never clears. Reading the interrupt with the enable off and on checks the masking.

// File: rtl/mdm_pkg.sv
// Package: shared constants for the modem control/status slice.
// Assumes byte-wide register port with a 3-bit address.
package mdm_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int CTRL_W    = 5;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd6;
    localparam int RTS_BIT   = 1;
    localparam int OUT2_BIT  = 3;
    localparam int RING_BIT  = 6;
    localparam int TRAIL_BIT = 2;
endpackage

// File: rtl/mdm_ctrl_reg.sv
// Module: control register and the two user outputs.
// Assumes synchronous active-low reset; outputs are active low and forced
// inactive while loop test is on.
module mdm_ctrl_reg
    import mdm_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                loop_en,
    output logic [W-1:0]        ctrl_q,
    output logic                rts_n,
    output logic                out2_n
);
    // Purpose: hold the writable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata[W-1:0];
    end

    // Purpose: map control bits to active-low pins with loop override.
    always_comb begin
        rts_n  = ~(ctrl_q[RTS_BIT]  & ~loop_en);
        out2_n = ~(ctrl_q[OUT2_BIT] & ~loop_en);
    end

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> ctrl_q == $past(wdata[W-1:0])); // R2
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_q)); // R5
endmodule

// File: rtl/mdm_ring_det.sv
// Module: ring-indicator synchroniser, trailing-edge detector and sticky flag.
// Assumes ri_n is asynchronous and idles high; the chain resets to high so
// that reset release never looks like an edge.
module mdm_ring_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ri_n,
    input  logic rd_stat,
    output logic ri_sync_n,
    output logic trail_flag,
    output logic trail_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   ri_prev_n;

    // Purpose: shift the raw input through the synchroniser flops.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= ri_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign ri_sync_n = chain[LAST];

    // Purpose: keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ri_prev_n <= 1'b1;
        else        ri_prev_n <= ri_sync_n;
    end

    // Purpose: detect the low-to-high transition of the ring input.
    always_comb trail_evt = ri_sync_n & ~ri_prev_n;

    // Purpose: sticky flag, set by an event, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)         trail_flag <= 1'b0;
        else if (trail_evt) trail_flag <= 1'b1;
        else if (rd_stat)   trail_flag <= 1'b0;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        trail_evt |=> trail_flag); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !trail_evt) |=> !trail_flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_flag && !rd_stat) |=> trail_flag); // R8
    AST_FALL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!trail_flag && !ri_sync_n) |=> !trail_flag); // R7
endmodule

// File: rtl/mdm_stat_read.sv
// Module: read-data multiplexer and interrupt request.
// Assumes read data depends on the address only; unused bits read zero.
module mdm_stat_read
    import mdm_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      ctrl_q,
    input  logic              ri_sync_n,
    input  logic              trail_flag,
    input  logic              ms_irq_en,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] stat_v;

    // Purpose: assemble the modem status byte.
    always_comb begin
        stat_v            = '0;
        stat_v[RING_BIT]  = ~ri_sync_n;
        stat_v[TRAIL_BIT] = trail_flag;
    end

    // Purpose: select the register addressed by the host.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL)      rdata[W-1:0] = ctrl_q;
        else if (addr == ADDR_STAT) rdata = stat_v;
    end

    // Purpose: gate the ring flag with the interrupt enable.
    always_comb irq = trail_flag & ms_irq_en;
endmodule

// File: rtl/mdm_ctl_status.sv
// Module: top of the modem control/status slice.
// Assumes one register access per cycle; read strobe only clears the flag.
module mdm_ctl_status
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              loop_en,
    input  logic              ms_irq_en,
    input  logic              ri_n,
    output logic              rts_n,
    output logic              out2_n,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              ri_sync_n;
    logic              trail_flag;
    logic              trail_evt;
    logic              wr_ctrl;
    logic              rd_stat;

    // Purpose: decode access strobes.
    always_comb begin
        wr_ctrl = wr_en & (addr == ADDR_CTRL);
        rd_stat = rd_en & (addr == ADDR_STAT);
    end

    mdm_ctrl_reg #(.W(CTRL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
        .loop_en(loop_en), .ctrl_q(ctrl_q), .rts_n(rts_n), .out2_n(out2_n)
    );

    mdm_ring_det #(.SYNC_STAGES(2)) u_ring (
        .clk(clk), .rst_n(rst_n), .ri_n(ri_n), .rd_stat(rd_stat),
        .ri_sync_n(ri_sync_n), .trail_flag(trail_flag), .trail_evt(trail_evt)
    );

    mdm_stat_read #(.W(CTRL_W)) u_read (
        .addr(addr), .ctrl_q(ctrl_q), .ri_sync_n(ri_sync_n),
        .trail_flag(trail_flag), .ms_irq_en(ms_irq_en),
        .rdata(rdata), .irq(irq)
    );

    AST_RESET_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rts_n && out2_n && !irq)); // R1
    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (rts_n && out2_n)); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_irq_en |-> !irq); // R9
endmodule

// File: tb/sim_mdm_ctl_status.sv
module sim_mdm_ctl_status;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0, rd_en = 0, loop_en = 0, ms_irq_en = 0, ri_n = 1;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       rts_n, out2_n, irq;
    int total = 0, bad = 0;

    localparam logic [2:0] A_CTRL = 3'd4, A_STAT = 3'd6;

    always #4 clk = ~clk;

    mdm_ctl_status u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .loop_en(loop_en), .ms_irq_en(ms_irq_en),
        .ri_n(ri_n), .rts_n(rts_n), .out2_n(out2_n), .irq(irq)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic rd_clear();
        @(negedge clk); addr = A_STAT; rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        peek(A_CTRL, d);
        chk(d == 0, "R1 ctrl", d, 0);
        chk(rts_n && out2_n, "R1 pins", {rts_n, out2_n}, 3);
        peek(A_STAT, d);
        chk(d[2] == 0 && irq == 0, "R1 flag", {d[2], irq}, 0);

        // R2 R3 R4 R5 sweep over all control values and loop settings
        for (int lp = 0; lp < 2; lp++) begin
            for (int v = 0; v < 32; v++) begin
                loop_en = lp[0];
                wr(A_CTRL, 8'(v) | 8'he0);
                peek(A_CTRL, d);
                chk(d == 8'(v), "R2 readback", d, v);
                chk(rts_n == (lp[0] ? 1'b1 : ~v[1]), lp ? "R5 rts" : "R3 rts", rts_n, lp ? 1 : ~v[1]);
                chk(out2_n == (lp[0] ? 1'b1 : ~v[3]), lp ? "R5 out2" : "R4 out2", out2_n, lp ? 1 : ~v[3]);
            end
        end
        loop_en = 0;
        @(negedge clk);
        chk(rts_n == 0 && out2_n == 0, "R5 restore after loop", {rts_n, out2_n}, 0);

        // R6 R7 falling edge: bit6 follows after two edges, no flag
        ms_irq_en = 1;
        ri_n = 0;
        @(negedge clk); peek(A_STAT, d);
        chk(d[6] == 0, "R6 latency1", d[6], 0);
        @(negedge clk); peek(A_STAT, d);
        chk(d[6] == 1, "R6 after two edges", d[6], 1);
        @(negedge clk); @(negedge clk); peek(A_STAT, d);
        chk(d[2] == 0 && irq == 0, "R7 falling no set", d[2], 0);

        // R6 R7 rising edge
        ri_n = 1;
        @(negedge clk); peek(A_STAT, d);
        chk(d[6] == 1, "R6 rise latency1", d[6], 1);
        @(negedge clk); peek(A_STAT, d);
        chk(d[6] == 0 && d[2] == 0, "R7 not yet", d, 0);
        @(negedge clk); peek(A_STAT, d);
        chk(d == 8'h04, "R7 set R10 others zero", d, 8'h04);
        // R9 masking
        chk(irq == 1, "R9 irq on", irq, 1);
        ms_irq_en = 0; #1;
        chk(irq == 0, "R9 irq masked", irq, 0);
        ms_irq_en = 1;
        // R8 sticky without strobe
        repeat (4) @(negedge clk);
        peek(A_STAT, d);
        chk(d[2] == 1, "R8 sticky", d[2], 1);
        // R10 write to status ignored
        wr(A_STAT, 8'h00);
        peek(A_STAT, d);
        chk(d == 8'h04, "R10 stat write ignored", d, 8'h04);
        peek(A_CTRL, d);
        chk(d == 8'h1f, "R10 ctrl untouched", d, 8'h1f);

        // R8 read coinciding with a new rising event keeps the flag
        ri_n = 0;
        repeat (3) @(negedge clk);
        ri_n = 1;
        @(negedge clk); @(negedge clk);
        addr = A_STAT; rd_en = 1;
        @(negedge clk); rd_en = 0;
        peek(A_STAT, d);
        chk(d[2] == 1, "R8 same-cycle event", d[2], 1);
        // R8 plain read clears
        rd_clear();
        peek(A_STAT, d);
        chk(d[2] == 0, "R8 read clears", d[2], 0);
        chk(irq == 0, "R9 irq drops", irq, 0);

        // R1 reset mid-run
        ri_n = 0; repeat (3) @(negedge clk); ri_n = 1; repeat (3) @(negedge clk);
        rst_n = 0; @(negedge clk); rst_n = 1;
        peek(A_CTRL, d);
        chk(d == 0 && rts_n && out2_n, "R1 mid-run ctrl", d, 0);
        peek(A_STAT, d);
        chk(d[2] == 0 && irq == 0, "R1 mid-run flag", d[2], 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule